// File: doc/BRIEF.md
# FSK Serial Data Output Interface

This block takes the bit stream from a 1200-baud FSK demodulator and delivers it to a host microcontroller in one of two ways, selected by a pin. With the mode pin low the block is transparent: each demodulated bit is resynchronised to the system clock and sent to the data output as it arrives. The host then does its own framing. With the mode pin high the block frames each asynchronous character itself. It recognises the start bit, samples eight data bits at the middle of each bit period, and checks the stop bit. It then pulls an active-low ready line to tell the host a byte is waiting. The host reads the byte out by toggling its own serial clock.

The receiver runs only when FSK reception is enabled, carrier is present and the part is not powered down. When those conditions are not met the receiver is held idle, so speech or alert tones cannot produce characters. Power-down also drops any byte that is waiting and parks both outputs at their inactive level. Bit timing comes from a divider on the system clock. The default setting is 2983 clocks per bit, which suits a 3.579545 MHz reference at 1200 baud.

Top module: `fsk_data_if`

## Requirements
- R1: After reset, `data_out` is 1 and `ready_n` is 1.
- R2: With `mode_sel` = 0 and the receiver enabled, `data_out` equals the value `fsk_bit_in` had three clock cycles earlier (two synchroniser stages plus one output register).
- R3: With `mode_sel` = 0, `ready_n` stays 1 and toggling `host_clk` has no effect on `data_out`.
- R4: With `mode_sel` = 1, a frame is recognised in this order: one start bit of 0, then eight data bits with the least significant bit first, then one stop bit of 1. Each bit lasts `CLKS_PER_BIT` clocks and is sampled at mid-bit. A frame whose stop bit is 1 drives `ready_n` to 0.
- R5: With `mode_sel` = 1 and `ready_n` at 0, each rising edge of `host_clk` advances `data_out` to the next bit of the received byte, least significant bit first. The first edge presents bit 0.
- R6: `ready_n` returns to 1 after the eighth rising edge of `host_clk`. Further edges before a new byte arrives leave `data_out` and `ready_n` unchanged.
- R7: A frame whose stop bit samples as 0 is discarded and `ready_n` stays 1.
- R8: While `fsk_en` is 0 or `carrier_n` is 1, incoming frames produce no byte, and in mode 0 `data_out` is held at 1.
- R9: While `pwdn` is 1, `data_out` and `ready_n` are both 1 from the next cycle on. A byte that was waiting is dropped and does not reappear when `pwdn` returns to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fsk_bit_in | input | 1 | Demodulated FSK bit, asynchronous, idle high |
| carrier_n | input | 1 | Carrier detect, active low |
| fsk_en | input | 1 | FSK reception enable, active high |
| pwdn | input | 1 | Power-down, active high |
| mode_sel | input | 1 | 0 = raw passthrough, 1 = framed byte readout |
| host_clk | input | 1 | Host serial read clock, asynchronous |
| data_out | output | 1 | Serial data to host |
| ready_n | output | 1 | Byte waiting, active low |

## Verification
The bench builds the block with `CLKS_PER_BIT` = 8 and keeps the default eight data bits, least significant bit first. The short bit time lets the bench send all 256 byte values as complete frames in mode 1 and read each one back through the host clock. Within a few thousand cycles it also reaches the bad-stop-bit, gating, power-down and extra-edge cases, as well as mode 0 passthrough over both input levels.

// File: rtl/fsk_out_pkg.sv
package fsk_out_pkg;

   typedef enum logic [1:0] {
      RX_IDLE  = 2'd0,
      RX_START = 2'd1,
      RX_DATA  = 2'd2,
      RX_STOP  = 2'd3
   } rx_state_e;

endpackage

// File: rtl/fsk_sync.sv
module fsk_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("fsk_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{RST_VAL}};
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];

endmodule

// File: rtl/fsk_char_rx.sv
module fsk_char_rx
   import fsk_out_pkg::*;
#(
   parameter int CLKS_PER_BIT = 2983,
   parameter int DATA_BITS    = 8,
   parameter bit LSB_FIRST    = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 rx_en,
   input  logic                 rx_bit,
   output logic                 byte_valid,
   output logic [DATA_BITS-1:0] byte_data
);

   localparam int CW   = $clog2(CLKS_PER_BIT);
   localparam int BW   = $clog2(DATA_BITS);
   localparam logic [CW-1:0] HALF_CNT = CW'((CLKS_PER_BIT - 1) / 2);
   localparam logic [CW-1:0] FULL_CNT = CW'(CLKS_PER_BIT - 1);
   localparam logic [BW-1:0] LAST_BIT = BW'(DATA_BITS - 1);

   generate
      if (CLKS_PER_BIT < 4) begin : g_bad_cpb
         $error("fsk_char_rx: CLKS_PER_BIT must be at least 4");
      end
      if (DATA_BITS < 2) begin : g_bad_bits
         $error("fsk_char_rx: DATA_BITS must be at least 2");
      end
   endgenerate

   rx_state_e            state;
   logic [CW-1:0]        tick_cnt;
   logic [BW-1:0]        bit_idx;
   logic [DATA_BITS-1:0] shreg;
   logic [DATA_BITS-1:0] shreg_next;
   logic                 prev_bit;

   generate
      if (LSB_FIRST) begin : g_lsb_first
         assign shreg_next = {rx_bit, shreg[DATA_BITS-1:1]};
      end else begin : g_msb_first
         assign shreg_next = {shreg[DATA_BITS-2:0], rx_bit};
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= RX_IDLE;
         tick_cnt   <= '0;
         bit_idx    <= '0;
         shreg      <= '0;
         prev_bit   <= 1'b1;
         byte_valid <= 1'b0;
         byte_data  <= '0;
      end else begin
         byte_valid <= 1'b0;
         if (!rx_en) begin
            state    <= RX_IDLE;
            tick_cnt <= '0;
            bit_idx  <= '0;
            prev_bit <= 1'b1;
         end else begin
            prev_bit <= rx_bit;
            unique case (state)
               RX_IDLE: begin
                  tick_cnt <= '0;
                  bit_idx  <= '0;
                  if (prev_bit && !rx_bit) state <= RX_START;
               end
               RX_START: begin
                  if (tick_cnt == HALF_CNT) begin
                     tick_cnt <= '0;
                     state    <= rx_bit ? RX_IDLE : RX_DATA;
                  end else begin
                     tick_cnt <= tick_cnt + 1'b1;
                  end
               end
               RX_DATA: begin
                  if (tick_cnt == FULL_CNT) begin
                     tick_cnt <= '0;
                     shreg    <= shreg_next;
                     if (bit_idx == LAST_BIT) state <= RX_STOP;
                     else                     bit_idx <= bit_idx + 1'b1;
                  end else begin
                     tick_cnt <= tick_cnt + 1'b1;
                  end
               end
               RX_STOP: begin
                  if (tick_cnt == FULL_CNT) begin
                     tick_cnt   <= '0;
                     state      <= RX_IDLE;
                     byte_valid <= rx_bit;
                     byte_data  <= shreg;
                  end else begin
                     tick_cnt <= tick_cnt + 1'b1;
                  end
               end
               default: state <= RX_IDLE;
            endcase
         end
      end
   end

   AST_RX_PARKED_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_en |=> (state == RX_IDLE && !byte_valid)); // R8

   AST_VALID_NEEDS_STOP: assert property (@(posedge clk) disable iff (!rst_n)
      byte_valid |-> ($past(state) == RX_STOP && $past(rx_bit))); // R7

endmodule

// File: rtl/fsk_host_shift.sv
module fsk_host_shift #(
   parameter int DATA_BITS = 8,
   parameter bit LSB_FIRST = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 active,
   input  logic                 load,
   input  logic [DATA_BITS-1:0] load_data,
   input  logic                 host_rise,
   output logic                 bit_out,
   output logic                 ready_n
);

   localparam int CNTW = $clog2(DATA_BITS + 1);
   localparam int IDXW = $clog2(DATA_BITS);
   localparam logic [CNTW-1:0] LAST_EDGE = CNTW'(DATA_BITS - 1);

   logic [DATA_BITS-1:0] held;
   logic [CNTW-1:0]      edge_cnt;
   logic [IDXW-1:0]      idx;
   logic [IDXW-1:0]      sel;

   assign idx = edge_cnt[IDXW-1:0];

   generate
      if (LSB_FIRST) begin : g_lsb_order
         assign sel = idx;
      end else begin : g_msb_order
         assign sel = IDXW'(DATA_BITS - 1) - idx;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         held     <= '0;
         edge_cnt <= '0;
         bit_out  <= 1'b1;
         ready_n  <= 1'b1;
      end else if (!active) begin
         held     <= '0;
         edge_cnt <= '0;
         bit_out  <= 1'b1;
         ready_n  <= 1'b1;
      end else if (load) begin
         held     <= load_data;
         edge_cnt <= '0;
         ready_n  <= 1'b0;
      end else if (host_rise && !ready_n) begin
         bit_out  <= held[sel];
         edge_cnt <= edge_cnt + 1'b1;
         if (edge_cnt == LAST_EDGE) ready_n <= 1'b1;
      end
   end

   AST_EDGE_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      edge_cnt <= CNTW'(DATA_BITS)); // R6

   AST_IDLE_HOLDS_BIT: assert property (@(posedge clk) disable iff (!rst_n)
      (active && ready_n && !load) |=> $stable(bit_out)); // R6

endmodule

// File: rtl/fsk_data_if.sv
module fsk_data_if #(
   parameter int CLKS_PER_BIT = 2983,
   parameter int DATA_BITS    = 8,
   parameter int SYNC_STAGES  = 2,
   parameter bit LSB_FIRST    = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic fsk_bit_in,
   input  logic carrier_n,
   input  logic fsk_en,
   input  logic pwdn,
   input  logic mode_sel,
   input  logic host_clk,
   output logic data_out,
   output logic ready_n
);

   logic                 bit_s;
   logic                 hclk_s;
   logic                 hclk_prev;
   logic                 host_rise;
   logic                 rx_en;
   logic                 pass_q;
   logic                 rx_valid;
   logic [DATA_BITS-1:0] rx_byte;
   logic                 shift_bit;
   logic                 framed_active;

   fsk_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_bit_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (fsk_bit_in),
      .q     (bit_s)
   );

   fsk_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_hclk_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (host_clk),
      .q     (hclk_s)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) hclk_prev <= 1'b0;
      else        hclk_prev <= hclk_s;
   end

   assign host_rise     = hclk_s && !hclk_prev;
   assign rx_en         = fsk_en && !carrier_n && !pwdn;
   assign framed_active = mode_sel && !pwdn;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      pass_q <= 1'b1;
      else if (rx_en)  pass_q <= bit_s;
      else             pass_q <= 1'b1;
   end

   fsk_char_rx #(
      .CLKS_PER_BIT (CLKS_PER_BIT),
      .DATA_BITS    (DATA_BITS),
      .LSB_FIRST    (LSB_FIRST)
   ) u_rx (
      .clk        (clk),
      .rst_n      (rst_n),
      .rx_en      (rx_en && mode_sel),
      .rx_bit     (bit_s),
      .byte_valid (rx_valid),
      .byte_data  (rx_byte)
   );

   fsk_host_shift #(
      .DATA_BITS (DATA_BITS),
      .LSB_FIRST (LSB_FIRST)
   ) u_shift (
      .clk       (clk),
      .rst_n     (rst_n),
      .active    (framed_active),
      .load      (rx_valid),
      .load_data (rx_byte),
      .host_rise (host_rise),
      .bit_out   (shift_bit),
      .ready_n   (ready_n)
   );

   assign data_out = mode_sel ? shift_bit : pass_q;

   AST_PWDN_OUTPUTS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      pwdn |=> (ready_n && data_out)); // R9

   AST_MODE0_NO_READY: assert property (@(posedge clk) disable iff (!rst_n)
      !mode_sel |=> ready_n); // R3

   AST_READY_FROM_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ready_n) |-> $past(rx_valid)); // R4

   AST_GATED_PASS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      (!fsk_en || carrier_n) |=> pass_q); // R8

endmodule

// File: tb/tb_fsk_data_if.sv
module tb_fsk_data_if;

   localparam int CPB = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic fsk_bit_in = 1'b1;
   logic carrier_n = 1'b0;
   logic fsk_en = 1'b1;
   logic pwdn = 1'b0;
   logic mode_sel = 1'b0;
   logic host_clk = 1'b0;
   logic data_out;
   logic ready_n;

   int checks = 0;
   int fails  = 0;
   int cycles = 0;

   always #4 clk = ~clk;

   fsk_data_if #(.CLKS_PER_BIT(CPB)) dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .fsk_bit_in (fsk_bit_in),
      .carrier_n  (carrier_n),
      .fsk_en     (fsk_en),
      .pwdn       (pwdn),
      .mode_sel   (mode_sel),
      .host_clk   (host_clk),
      .data_out   (data_out),
      .ready_n    (ready_n)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wait_cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic send_frame(input logic [7:0] b, input logic stop_bit);
      fsk_bit_in = 1'b0;
      wait_cyc(CPB);
      for (int i = 0; i < 8; i++) begin
         fsk_bit_in = b[i];
         wait_cyc(CPB);
      end
      fsk_bit_in = stop_bit;
      wait_cyc(CPB);
      fsk_bit_in = 1'b1;
      wait_cyc(2 * CPB);
   endtask

   task automatic host_edge();
      host_clk = 1'b1;
      wait_cyc(5);
      host_clk = 1'b0;
      wait_cyc(5);
   endtask

   task automatic read_byte(output logic [7:0] b, output logic rdy_after);
      for (int i = 0; i < 8; i++) begin
         host_clk = 1'b1;
         wait_cyc(5);
         b[i] = data_out;
         host_clk = 1'b0;
         wait_cyc(5);
      end
      rdy_after = ready_n;
   endtask

   initial begin
      while (cycles < 200000) begin
         @(posedge clk);
         cycles++;
      end
      fails++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 0);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      logic [7:0] got;
      logic       rdy;
      logic       hold;

      wait_cyc(3);
      check(data_out === 1'b1, "R1 data_out after reset", data_out, 1);
      check(ready_n === 1'b1, "R1 ready_n after reset", ready_n, 1);
      rst_n = 1'b1;
      wait_cyc(3);

      // R2: passthrough with exact three-cycle latency
      mode_sel = 1'b0;
      for (int v = 0; v < 2; v++) begin
         fsk_bit_in = v[0];
         wait_cyc(2);
         check(data_out === ~v[0], "R2 latency not before 3 cycles", data_out, ~v[0]);
         wait_cyc(1);
         check(data_out === v[0], "R2 passthrough", data_out, v[0]);
      end
      for (int p = 0; p < 16; p++) begin
         fsk_bit_in = p[0] ^ p[2];
         wait_cyc(3);
         check(data_out === (p[0] ^ p[2]), "R2 pattern", data_out, p[0] ^ p[2]);
      end

      // R3: host clock ignored in mode 0
      fsk_bit_in = 1'b0;
      wait_cyc(4);
      for (int k = 0; k < 4; k++) host_edge();
      check(data_out === 1'b0, "R3 host_clk ignored", data_out, 0);
      check(ready_n === 1'b1, "R3 ready_n idle in mode 0", ready_n, 1);
      fsk_bit_in = 1'b1;
      wait_cyc(4);

      // R8: gated in mode 0
      fsk_en = 1'b0;
      fsk_bit_in = 1'b0;
      wait_cyc(4);
      check(data_out === 1'b1, "R8 fsk_en low holds data_out", data_out, 1);
      fsk_en = 1'b1;
      carrier_n = 1'b1;
      wait_cyc(4);
      check(data_out === 1'b1, "R8 no carrier holds data_out", data_out, 1);
      carrier_n = 1'b0;
      fsk_bit_in = 1'b1;
      wait_cyc(4);

      // R4 R5 R6: all byte values
      mode_sel = 1'b1;
      wait_cyc(4);
      for (int v = 0; v < 256; v++) begin
         send_frame(v[7:0], 1'b1);
         check(ready_n === 1'b0, "R4 ready_n after good frame", ready_n, 0);
         read_byte(got, rdy);
         check(got === v[7:0], "R5 byte readout", got, v);
         check(rdy === 1'b1, "R6 ready_n after eighth edge", rdy, 1);
      end

      // R6: extra edges leave outputs alone
      hold = data_out;
      for (int k = 0; k < 3; k++) host_edge();
      check(data_out === hold, "R6 extra edges data_out", data_out, hold);
      check(ready_n === 1'b1, "R6 extra edges ready_n", ready_n, 1);

      // R7: bad stop bit discarded
      send_frame(8'hA5, 1'b0);
      wait_cyc(CPB);
      check(ready_n === 1'b1, "R7 bad stop discarded", ready_n, 1);
      send_frame(8'h3C, 1'b1);
      read_byte(got, rdy);
      check(got === 8'h3C, "R7 recovery after bad stop", got, 8'h3C);

      // R8: gated in mode 1
      fsk_en = 1'b0;
      send_frame(8'h55, 1'b1);
      check(ready_n === 1'b1, "R8 fsk_en low no byte", ready_n, 1);
      fsk_en = 1'b1;
      carrier_n = 1'b1;
      send_frame(8'h55, 1'b1);
      check(ready_n === 1'b1, "R8 no carrier no byte", ready_n, 1);
      carrier_n = 1'b0;
      wait_cyc(4);

      // R9: power-down drops waiting byte
      send_frame(8'h0F, 1'b1);
      check(ready_n === 1'b0, "R9 byte waiting before pwdn", ready_n, 0);
      host_edge();
      pwdn = 1'b1;
      wait_cyc(2);
      check(ready_n === 1'b1, "R9 ready_n in pwdn", ready_n, 1);
      check(data_out === 1'b1, "R9 data_out in pwdn", data_out, 1);
      send_frame(8'h81, 1'b1);
      check(ready_n === 1'b1, "R9 no byte in pwdn", ready_n, 1);
      pwdn = 1'b0;
      wait_cyc(4);
      check(ready_n === 1'b1, "R9 byte dropped", ready_n, 1);
      mode_sel = 1'b0;
      pwdn = 1'b1;
      fsk_bit_in = 1'b0;
      wait_cyc(4);
      check(data_out === 1'b1, "R9 mode 0 data_out in pwdn", data_out, 1);
      pwdn = 1'b0;
      fsk_bit_in = 1'b1;
      wait_cyc(4);

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule